// File: doc/BRIEF.md
# Serial Port Control and Status Register File

This block is the software-facing register set of a serial port. On one side is a simple word-indexed bus with separate read and write strobes and 32-bit data. On the other side are a byte-wide receive stream and a byte-wide transmit stream. The bit shifter, the baud generator, any FIFOs and any modem pins are outside this block.

Received characters land in a single-entry holding buffer. Software empties it with a destructive read of the receive-data word. While the buffer is full, the block refuses further characters by dropping its ready output. A byte written to the transmit-data word goes out on the byte output only while the transmitter is enabled. Two status words carry write-one-to-clear bits. One level interrupt reports receive-ready and transmit-ready, each under its own enable bit. A write to control word 2 with bit 0 low puts every register back to its reset value.

The baud, FIFO-control and millisecond words only store what software writes, so that it can be read back. Every register update, the interrupt and every output pulse become visible on the clock edge after the access that causes them. Read data is combinational from the current register contents.

Top module: `sercsr_top`

## Requirements
- R1: Writes to word indices 0x20 (control 1), 0x22 (control 3), 0x24 (FIFO control), 0x2A (modulator) and 0x2C (millisecond) keep the low 16 bits of the written value, and the same index reads them back. A write to 0x29 stores its low 16 bits into the baud count word, which reads back at 0x2B.
- R2: After reset, and after a soft reset, the words read as follows: status 1 (0x25) = 0x6040, status 2 (0x26) = 0x4028, test (0x2D) = 0x0060, control 1 = 0, control 2 (0x21) = 0x0001, control 3 = 0x0700, baud count = 0x0004, receive data (0x00) = 0x4000. All other stored words read 0. The interrupt and all output pulses are low.
- R3: Reading index 0x00 returns the buffered word. When the buffer is full, the read also sets bit 15, and the following edge clears status-1 bit 9, clears status-2 bit 0 and sets test bit 5. A one-cycle rx_accept pulse then follows. A read of an empty buffer changes nothing and gives no pulse.
- R4: A character offered on rx_valid is taken only while status-1 bit 9 is clear. rx_ready shows the inverse of that bit. Taking a character loads it into the buffer, sets status-1 bit 9 and status-2 bit 0, and clears test bit 5. A refused character leaves the buffer unchanged.
- R5: When a receive-data read of a full buffer and a new character arrive in the same cycle, the read takes effect and the character is refused.
- R6: A break event is taken under the same rule as a character and loads the buffer with 0x0800.
- R7: irq is high when status-1 bit 9 and control-1 bit 9 are both set, or when status-1 bit 13, control-1 bit 13 and control-1 bit 6 are all set. It is registered from the values that take effect on the same edge.
- R8: A write to status 1 clears only those set bits that are also in mask 0x9DB0. A write to status 2 clears only those set bits that are also in mask 0xBDD6. Every other bit ignores the write.
- R9: A write to index 0x10 produces a one-cycle tx_valid pulse carrying the low byte only if control-2 bit 2 is set. Otherwise the byte is dropped.
- R10: A write to control 2 with bit 0 low restores every register to its reset value. Control 2 then holds the written low 16 bits with bit 0 forced to 1. A write with bit 0 high only stores the value.
- R11: A control-2 write that sets bit 1 while the previous bit 1 was clear gives an rx_accept pulse. The previous bit counts as clear after a soft reset in the same write.
- R12: Indices 0x23 and 0x29 and any unmapped index read 0. Writes to the test word 0x2D and to unmapped indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | 6 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx, combinational |
| rx_valid | input | 1 | Incoming character offered |
| rx_break | input | 1 | Break event offered |
| rx_char | input | 8 | Incoming character |
| rx_ready | output | 1 | Buffer can take a character |
| rx_accept | output | 1 | One-cycle pulse telling the source to resume |
| tx_valid | output | 1 | One-cycle pulse with a transmit byte |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The in-line assertions run on every cycle. They check that the receive flags in the three status words stay in agreement, that a full buffer never changes, that a read wins over a character in the same cycle, that the interrupt matches the stored status and enables, that tx_valid follows the enable, and that control-2 bit 0 reads as set after any write. Other behaviour can only be shown by the bench's scenarios, which compare every output against a behavioural model on every clock. Those scenarios cover the exact reset and soft-reset contents, the read-back of the stored words, the moved baud-count index, the write-one-to-clear masks, the break word, and the receive-enable edge that follows a soft reset.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;

  localparam int IDX_W  = 6;
  localparam int REG_W  = 16;
  localparam int NPLAIN = 6;

  // word indices
  localparam logic [IDX_W-1:0] IX_RXD  = 6'h00;
  localparam logic [IDX_W-1:0] IX_TXD  = 6'h10;
  localparam logic [IDX_W-1:0] IX_CR1  = 6'h20;
  localparam logic [IDX_W-1:0] IX_CR2  = 6'h21;
  localparam logic [IDX_W-1:0] IX_CR3  = 6'h22;
  localparam logic [IDX_W-1:0] IX_FCR  = 6'h24;
  localparam logic [IDX_W-1:0] IX_SR1  = 6'h25;
  localparam logic [IDX_W-1:0] IX_SR2  = 6'h26;
  localparam logic [IDX_W-1:0] IX_BINC = 6'h29;
  localparam logic [IDX_W-1:0] IX_BMOD = 6'h2A;
  localparam logic [IDX_W-1:0] IX_BCNT = 6'h2B;
  localparam logic [IDX_W-1:0] IX_MS   = 6'h2C;
  localparam logic [IDX_W-1:0] IX_TST  = 6'h2D;

  // bit positions that the logic decodes
  localparam int B_S1_TRDY    = 13;
  localparam int B_S1_RRDY    = 9;
  localparam int B_S2_RDR     = 0;
  localparam int B_T_RXE      = 5;
  localparam int B_CR1_TRDYEN = 13;
  localparam int B_CR1_RRDYEN = 9;
  localparam int B_CR1_TXEEN  = 6;
  localparam int B_CR2_TXEN   = 2;
  localparam int B_CR2_RXEN   = 1;
  localparam int B_CR2_SRST   = 0;
  localparam int B_RX_CHRDY   = 15;

  // clearable bit masks and reset contents
  localparam logic [REG_W-1:0] S1_W1C    = 16'h9DB0;
  localparam logic [REG_W-1:0] S2_W1C    = 16'hBDD6;
  localparam logic [REG_W-1:0] S1_RST    = 16'h6040;
  localparam logic [REG_W-1:0] S2_RST    = 16'h4028;
  localparam logic [REG_W-1:0] TST_RST   = 16'h0060;
  localparam logic [REG_W-1:0] CR2_RST   = 16'h0001;
  localparam logic [REG_W-1:0] RXBUF_RST = 16'h4000;
  localparam logic [REG_W-1:0] BRK_WORD  = 16'h0800;

  // slots of the plain storage words
  localparam int PL_CR1  = 0;
  localparam int PL_CR3  = 1;
  localparam int PL_FCR  = 2;
  localparam int PL_BMOD = 3;
  localparam int PL_BCNT = 4;
  localparam int PL_MS   = 5;

  function automatic logic [IDX_W-1:0] plain_widx(input int k);
    case (k)
      PL_CR1:  return IX_CR1;
      PL_CR3:  return IX_CR3;
      PL_FCR:  return IX_FCR;
      PL_BMOD: return IX_BMOD;
      PL_BCNT: return IX_BINC;
      default: return IX_MS;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] plain_ridx(input int k);
    case (k)
      PL_CR1:  return IX_CR1;
      PL_CR3:  return IX_CR3;
      PL_FCR:  return IX_FCR;
      PL_BMOD: return IX_BMOD;
      PL_BCNT: return IX_BCNT;
      default: return IX_MS;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] plain_rst(input int k);
    case (k)
      PL_CR3:  return 16'h0700;
      PL_BCNT: return 16'h0004;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/sercsr_cfg.sv
module sercsr_cfg
  import sercsr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             idx,
  input  logic [REG_W-1:0]             wdat,
  output logic                         soft_rst,
  output logic [NPLAIN-1:0][REG_W-1:0] plain_q,
  output logic [REG_W-1:0]             cr1_nxt,
  output logic [REG_W-1:0]             cr2_q,
  output logic                         tx_valid_q,
  output logic [CHAR_W-1:0]            tx_data_q,
  output logic                         rxen_kick_q
);

  localparam logic [REG_W-1:0] SRST_SET = REG_W'(1) << B_CR2_SRST;

  logic                         cr2_wr;
  logic                         rxen_prev;
  logic                         kick_nxt;
  logic                         tx_fire;
  logic [REG_W-1:0]             cr2_nxt;
  logic [NPLAIN-1:0][REG_W-1:0] plain_nxt;

  assign cr2_wr    = wr_en && (idx == IX_CR2);
  assign soft_rst  = cr2_wr && !wdat[B_CR2_SRST];
  assign rxen_prev = soft_rst ? 1'b0 : cr2_q[B_CR2_RXEN];
  assign kick_nxt  = cr2_wr && wdat[B_CR2_RXEN] && !rxen_prev;
  assign tx_fire   = wr_en && (idx == IX_TXD) && cr2_q[B_CR2_TXEN];
  assign cr1_nxt   = plain_nxt[PL_CR1];

  always_comb begin
    cr2_nxt = cr2_q;
    if (cr2_wr) cr2_nxt = wdat | SRST_SET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr2_q       <= CR2_RST;
      rxen_kick_q <= 1'b0;
      tx_valid_q  <= 1'b0;
    end else begin
      cr2_q       <= cr2_nxt;
      rxen_kick_q <= kick_nxt;
      tx_valid_q  <= tx_fire;
    end
  end

  // data path register: clock enable only, no reset needed
  always_ff @(posedge clk) begin
    if (tx_fire) tx_data_q <= wdat[CHAR_W-1:0];
  end

  // plain storage words, one register per slot
  for (genvar k = 0; k < NPLAIN; k++) begin : g_plain
    logic [REG_W-1:0] r_q;
    logic [REG_W-1:0] r_nxt;
    logic             r_en;

    assign r_en = soft_rst || (wr_en && (idx == plain_widx(k)));

    always_comb begin
      r_nxt = r_q;
      if (soft_rst)  r_nxt = plain_rst(k);
      else if (r_en) r_nxt = wdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= plain_rst(k);
      else if (r_en) r_q <= r_nxt;
    end

    assign plain_q[k]   = r_q;
    assign plain_nxt[k] = r_nxt;
  end

  // R9: a byte leaves only if the transmitter was enabled at the write
  p_tx_gate_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_q |-> $past(cr2_q[B_CR2_TXEN]));

  // R10: control 2 always reads with bit 0 set after any write to it
  p_srst_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    cr2_wr |=> cr2_q[B_CR2_SRST]);

  // R10: a soft reset puts the baud count back to its reset value
  p_srst_bcnt_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (plain_q[PL_BCNT] == 16'h0004));

endmodule

// File: rtl/sercsr_stat.sv
module sercsr_stat
  import sercsr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  wdat,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [CHAR_W-1:0] rx_char,
  output logic [REG_W-1:0]  s1_q,
  output logic [REG_W-1:0]  s2_q,
  output logic [REG_W-1:0]  tst_q,
  output logic [REG_W-1:0]  rxbuf_q,
  output logic [REG_W-1:0]  s1_nxt,
  output logic              rx_ready,
  output logic              rd_kick_q
);

  logic             rd_hit;
  logic             rx_req;
  logic             take;
  logic [REG_W-1:0] s2_nxt;
  logic [REG_W-1:0] tst_nxt;
  logic [REG_W-1:0] rxbuf_nxt;

  assign rx_ready = !s1_q[B_S1_RRDY];
  assign rd_hit   = rd_en && (idx == IX_RXD) && !tst_q[B_T_RXE];
  assign rx_req   = rx_valid || rx_break;
  assign take     = rx_req && rx_ready;

  always_comb begin
    s1_nxt    = s1_q;
    s2_nxt    = s2_q;
    tst_nxt   = tst_q;
    rxbuf_nxt = rxbuf_q;
    if (wr_en && (idx == IX_SR1)) s1_nxt = s1_nxt & ~(wdat & S1_W1C);
    if (wr_en && (idx == IX_SR2)) s2_nxt = s2_nxt & ~(wdat & S2_W1C);
    if (rd_hit) begin
      s1_nxt[B_S1_RRDY] = 1'b0;
      s2_nxt[B_S2_RDR]  = 1'b0;
      tst_nxt[B_T_RXE]  = 1'b1;
    end
    if (take) begin
      rxbuf_nxt         = rx_break ? BRK_WORD : REG_W'(rx_char);
      s1_nxt[B_S1_RRDY] = 1'b1;
      s2_nxt[B_S2_RDR]  = 1'b1;
      tst_nxt[B_T_RXE]  = 1'b0;
    end
    if (soft_rst) begin
      s1_nxt    = S1_RST;
      s2_nxt    = S2_RST;
      tst_nxt   = TST_RST;
      rxbuf_nxt = RXBUF_RST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q      <= S1_RST;
      s2_q      <= S2_RST;
      tst_q     <= TST_RST;
      rxbuf_q   <= RXBUF_RST;
      rd_kick_q <= 1'b0;
    end else begin
      s1_q      <= s1_nxt;
      s2_q      <= s2_nxt;
      tst_q     <= tst_nxt;
      rd_kick_q <= rd_hit;
      if (take || soft_rst) rxbuf_q <= rxbuf_nxt;
    end
  end

  // R4: the three receive flags always agree
  p_flags_agree_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (s1_q[B_S1_RRDY] == s2_q[B_S2_RDR]) && (s1_q[B_S1_RRDY] == !tst_q[B_T_RXE]));

  // R4: a full buffer is never overwritten
  p_refuse_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (s1_q[B_S1_RRDY] && !soft_rst) |=> $stable(rxbuf_q));

  // R3: a read of a full buffer leaves it empty
  p_rdclr_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !soft_rst) |=> (tst_q[B_T_RXE] && !s1_q[B_S1_RRDY]));

  // R5: a read and a character in the same cycle: the read wins
  p_rd_wins_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rx_req) |=> (tst_q[B_T_RXE] && !s2_q[B_S2_RDR]));

endmodule

// File: rtl/sercsr_top.sv
module sercsr_top
  import sercsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              rx_ready,
  output logic              rx_accept,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              irq
);

  logic [REG_W-1:0]             wdat;
  logic [DATA_W-REG_W-1:0]      unused_wdata_hi;
  logic                         soft_rst;
  logic [NPLAIN-1:0][REG_W-1:0] plain_q;
  logic [REG_W-1:0]             cr1_nxt;
  logic [REG_W-1:0]             cr2_q;
  logic                         rxen_kick_q;
  logic [REG_W-1:0]             s1_q;
  logic [REG_W-1:0]             s2_q;
  logic [REG_W-1:0]             tst_q;
  logic [REG_W-1:0]             rxbuf_q;
  logic [REG_W-1:0]             s1_nxt;
  logic                         rd_kick_q;
  logic [REG_W-1:0]             rd16;
  logic                         irq_nxt;
  logic                         irq_q;
  logic [REG_W-1:0]             cr1_q;

  assign wdat            = bus_wdata[REG_W-1:0];
  assign unused_wdata_hi = bus_wdata[DATA_W-1:REG_W];
  assign cr1_q           = plain_q[PL_CR1];

  sercsr_cfg #(.CHAR_W(CHAR_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_wr),
    .idx         (bus_idx),
    .wdat        (wdat),
    .soft_rst    (soft_rst),
    .plain_q     (plain_q),
    .cr1_nxt     (cr1_nxt),
    .cr2_q       (cr2_q),
    .tx_valid_q  (tx_valid),
    .tx_data_q   (tx_data),
    .rxen_kick_q (rxen_kick_q)
  );

  sercsr_stat #(.CHAR_W(CHAR_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .idx       (bus_idx),
    .wdat      (wdat),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .rx_char   (rx_char),
    .s1_q      (s1_q),
    .s2_q      (s2_q),
    .tst_q     (tst_q),
    .rxbuf_q   (rxbuf_q),
    .s1_nxt    (s1_nxt),
    .rx_ready  (rx_ready),
    .rd_kick_q (rd_kick_q)
  );

  // read multiplexer, combinational from current contents
  always_comb begin
    rd16 = '0;
    case (bus_idx)
      IX_RXD: begin
        rd16 = rxbuf_q;
        if (!tst_q[B_T_RXE]) rd16[B_RX_CHRDY] = 1'b1;
      end
      IX_CR2: rd16 = cr2_q;
      IX_SR1: rd16 = s1_q;
      IX_SR2: rd16 = s2_q;
      IX_TST: rd16 = tst_q;
      default: begin
        for (int k = 0; k < NPLAIN; k++) begin
          if (bus_idx == plain_ridx(k)) rd16 = plain_q[k];
        end
      end
    endcase
  end

  assign bus_rdata = DATA_W'(rd16);
  assign rx_accept = rxen_kick_q | rd_kick_q;

  // interrupt from the values that take effect on this edge
  assign irq_nxt = (s1_nxt[B_S1_RRDY] && cr1_nxt[B_CR1_RRDYEN]) ||
                   (s1_nxt[B_S1_TRDY] && cr1_nxt[B_CR1_TRDYEN] && cr1_nxt[B_CR1_TXEEN]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end

  assign irq = irq_q;

  // R7: the registered interrupt matches the stored status and enables
  p_irq_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((s1_q[B_S1_RRDY] && cr1_q[B_CR1_RRDYEN]) ||
            (s1_q[B_S1_TRDY] && cr1_q[B_CR1_TRDYEN] && cr1_q[B_CR1_TXEEN])));

endmodule

// File: tb/sercsr_top_test.sv
module sercsr_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_idx;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_valid, rx_break;
  logic [7:0]  rx_char;
  logic        rx_ready, rx_accept, tx_valid, irq;
  logic [7:0]  tx_data;

  always #5 clk = ~clk;

  sercsr_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_break(rx_break), .rx_char(rx_char),
    .rx_ready(rx_ready), .rx_accept(rx_accept), .tx_valid(tx_valid),
    .tx_data(tx_data), .irq(irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur = "R2";

  // behavioural model state
  int m_s1, m_s2, m_ts, m_rb, m_c1, m_c2, m_c3, m_fc, m_bm, m_bc, m_ms;
  int m_txd;
  bit m_txv, m_acc, m_irq;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_s1 = 'h6040; m_s2 = 'h4028; m_ts = 'h0060; m_rb = 'h4000;
    m_c1 = 0; m_c2 = 1; m_c3 = 'h0700; m_fc = 0; m_bm = 0; m_bc = 4; m_ms = 0;
  endtask

  function automatic int m_read(int ix);
    case (ix)
      'h00: return m_rb | (((m_ts & 'h20) != 0) ? 0 : 'h8000);
      'h20: return m_c1;
      'h21: return m_c2;
      'h22: return m_c3;
      'h24: return m_fc;
      'h25: return m_s1;
      'h26: return m_s2;
      'h2A: return m_bm;
      'h2B: return m_bc;
      'h2C: return m_ms;
      'h2D: return m_ts;
      default: return 0;
    endcase
  endfunction

  task automatic m_update();
    int w;
    bit rdhit, take, old_rxen;
    w = int'(bus_wdata) & 'hFFFF;
    rdhit = bus_rd && (bus_idx == 0) && ((m_ts & 'h20) == 0);
    take  = (rx_valid || rx_break) && ((m_s1 & 'h200) == 0);
    m_acc = rdhit;
    m_txv = 1'b0;
    if (rdhit) begin
      m_s1 &= ~'h200; m_s2 &= ~1; m_ts |= 'h20;
    end
    if (take) begin
      m_rb = rx_break ? 'h0800 : int'(rx_char);
      m_s1 |= 'h200; m_s2 |= 1; m_ts &= ~'h20;
    end
    if (bus_wr) begin
      case (int'(bus_idx))
        'h10: if ((m_c2 & 4) != 0) begin m_txv = 1'b1; m_txd = w & 'hFF; end
        'h20: m_c1 = w;
        'h22: m_c3 = w;
        'h24: m_fc = w;
        'h29: m_bc = w;
        'h2A: m_bm = w;
        'h2C: m_ms = w;
        'h25: m_s1 &= ~(w & 'h9DB0);
        'h26: m_s2 &= ~(w & 'hBDD6);
        'h21: begin
          old_rxen = ((m_c2 >> 1) & 1) != 0;
          if ((w & 1) == 0) begin
            m_reset();
            old_rxen = 1'b0;
          end
          m_c2 = w | 1;
          if (((w & 2) != 0) && !old_rxen) m_acc = 1'b1;
        end
        default: ;
      endcase
    end
    m_irq = (((m_s1 & m_c1 & 'h200) != 0)) ||
            (((m_s1 & m_c1 & 'h2000) != 0) && ((m_c1 & 'h40) != 0));
  endtask

  // one clock: combinational checks before the edge, registered after it
  task automatic tick();
    #1;
    if (bus_rd) chk("bus_rdata", bus_rdata, m_read(int'(bus_idx)));
    chk("rx_ready", {31'b0, rx_ready}, {31'b0, ((m_s1 & 'h200) == 0)});
    @(posedge clk);
    m_update();
    @(negedge clk);
    chk("irq", {31'b0, irq}, {31'b0, m_irq});
    chk("tx_valid", {31'b0, tx_valid}, {31'b0, m_txv});
    chk("rx_accept", {31'b0, rx_accept}, {31'b0, m_acc});
    if (m_txv) chk("tx_data", {24'b0, tx_data}, m_txd);
  endtask

  task automatic op(bit wr, bit rd, int ix, int wd, bit rv, bit rb, int ch);
    bus_wr = wr; bus_rd = rd; bus_idx = ix[5:0]; bus_wdata = wd;
    rx_valid = rv; rx_break = rb; rx_char = ch[7:0];
    tick();
  endtask

  task automatic idle();           op(0, 0, 0, 0, 0, 0, 0);  endtask
  task automatic wr(int ix, int v); op(1, 0, ix, v, 0, 0, 0); endtask
  task automatic rd(int ix);        op(0, 1, ix, 0, 0, 0, 0); endtask
  task automatic give(int c);       op(0, 0, 0, 0, 1, 0, c);  endtask

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL %s watchdog: actual timeout expected completion", cur);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 0; bus_idx = 0; bus_wdata = 0;
    rx_valid = 0; rx_break = 0; rx_char = 0;
    m_reset(); m_txv = 0; m_acc = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset contents of every index
    cur = "R2";
    for (int i = 0; i < 48; i++) rd(i);

    // R12: unmapped and zero-reading indices, ignored writes
    cur = "R12";
    rd('h23); rd('h29); rd('h30); rd('h3F);
    wr('h2D, 'hFFFF); rd('h2D);
    wr('h33, 'h1234); wr('h23, 'hFFFF); rd('h33); rd('h23);

    // R1: stored words read back their low 16 bits
    cur = "R1";
    wr('h20, 'hDEAD1234); rd('h20);
    wr('h22, 'hBEEF5678); rd('h22);
    wr('h24, 'h0001ABCD); rd('h24);
    wr('h2A, 'h00007777); rd('h2A);
    wr('h29, 'hFFFF0042); rd('h2B); rd('h29);
    wr('h2C, 'h000003E8); rd('h2C);
    wr('h20, 0);

    // R3: empty read gives the stored word without ready bit
    cur = "R3";
    rd('h00); idle();

    // R4: character taken, flags set, further characters refused
    cur = "R4";
    give('h5A); rd('h25); rd('h26); rd('h2D);
    give('hC3); give('h11); idle();

    // R3: destructive read then a repeat read
    cur = "R3";
    rd('h00); idle(); rd('h00); rd('h25); rd('h26); rd('h2D);

    // R5: read and new character in the same cycle
    cur = "R5";
    give('h21);
    op(0, 1, 'h00, 0, 1, 0, 'h99);
    rd('h00); rd('h25);
    give('h77); rd('h00); idle();

    // R6: break word
    cur = "R6";
    op(0, 0, 0, 0, 0, 1, 0); rd('h00); idle();

    // R7: interrupt under its enables
    cur = "R7";
    wr('h20, 'h0200); give('h3C); idle(); rd('h00); idle();
    wr('h20, 'h2000); idle();
    wr('h20, 'h2040); idle();
    wr('h20, 'h0040); idle();
    wr('h20, 'h2240); give('h01); rd('h00); idle();
    wr('h20, 0);

    // R8: masked clears leave unmaskable bits alone
    cur = "R8";
    give('h42);
    wr('h25, 'hFFFF); rd('h25);
    wr('h26, 'hFFFF); rd('h26);
    wr('h25, 'h6240); wr('h26, 'h4029); rd('h25); rd('h26);
    rd('h00);

    // R9: transmit gated by enable
    cur = "R9";
    wr('h10, 'h1A5); idle();
    wr('h21, 'h0005); rd('h21);
    wr('h10, 'h1A5); idle();
    wr('h10, 'h0F0); wr('h10, 'h00F); idle();
    wr('h21, 'h0001); wr('h10, 'h055); idle();

    // R11: receive-enable rising edge
    cur = "R11";
    wr('h21, 'h0003); idle();
    wr('h21, 'h0003); idle();
    wr('h21, 'h0001); wr('h21, 'h0003); idle();

    // R10: soft reset restores every word
    cur = "R10";
    wr('h20, 'h0200); wr('h22, 'h1111); wr('h29, 'h2222); wr('h2C, 'h3333);
    give('h66); idle();
    wr('h21, 'hFF00);
    for (int i = 0; i < 48; i++) rd(i);
    wr('h21, 'h0007); idle();
    cur = "R11";
    wr('h21, 'h0002); rd('h21); idle();
    cur = "R10";
    wr('h21, 'h0004); rd('h21); wr('h10, 'h0AA); idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule